// File: doc/BRIEF.md
# Stack Processor Eight-Bit ALU

This unit is the arithmetic and logic core of a small stack processor. A 6-bit operator code picks one function. The function is applied to two 8-bit operands, and the unit returns one 8-bit result word.

The functions are:
- bitwise inverse, AND, OR and XOR;
- a move that passes the second operand through;
- logical left and right shifts by a variable amount;
- wrapping add and subtract;
- parity and a count of set bits;
- three compares (equal, signed less-than, unsigned less-than) that return 0 or 1 in the result word.

The unit holds no state and has no clock. It produces no flags and no carry out. The result settles within the same cycle as its inputs. The processor around it supplies the operands from its stack and consumes the result.

The operator codes are sparse. A decoder turns the code into a set of one-hot select strobes. A datapath computes every function in parallel and merges the selected one onto the result. A code that selects nothing yields zero.

Top module: `stk_alu8`

## Requirements
- R1: Operator 000000 returns the bitwise inverse of operandA.
- R2: Operator 000100 returns the parity of operandA in bit 0: 1 when operandA holds an odd number of ones. Bits 7 to 1 are zero.
- R3: Operator 001000 returns the number of set bits in operandA, zero-extended to 8 bits.
- R4: Operators 001101, 010001 and 010101 return operandA AND, OR and XOR operandB, in that order.
- R5: Operator 011001 returns operandB unchanged.
- R6: Operator 011101 shifts operandA left and operator 100001 shifts it right, both logically. The shift amount is the unsigned value of operandB. An amount of 8 or more gives all zeros in both directions.
- R7: Operator 000010 returns operandA + operandB modulo 256.
- R8: Operator 000110 returns operandA − operandB modulo 256 (two's complement wrap).
- R9: Operator 000011 returns 1 when operandA equals operandB and 0 otherwise. Bits 7 to 1 are zero.
- R10: Operator 000111 returns 1 when operandA < operandB as two's-complement signed values, and 0 otherwise. Bits 7 to 1 are zero.
- R11: Operator 001011 returns 1 when operandA < operandB as unsigned values, and 0 otherwise. Bits 7 to 1 are zero.
- R12: Any operator code not named in R1 to R11 returns all zeros.
- R13: The result is combinational. It follows a change of any input with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 6 | Operator code selecting the function |
| operandA | input | 8 | First operand (shift source, count and parity source) |
| operandB | input | 8 | Second operand (shift amount, move source) |
| result | output | 8 | Function result |

## Verification
Two functions can meet in a single evaluation: the shift-range limit and the compare outcome. Both depend on operandB landing at or near 8, 127/128 or 255. Every 6-bit code is applied to every operandA value, and each pairing uses a list of operandB values clustered at those boundaries. The operator and both operands often change at the same instant. Each result is judged against an arithmetic model computed for the new triple: integer multiply and divide stand in for the shifts, and a signed reinterpretation stands in for the ordering.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;

  localparam int OP_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_NOT = 6'b000000,
    OP_ADD = 6'b000010,
    OP_SEQ = 6'b000011,
    OP_PAR = 6'b000100,
    OP_SUB = 6'b000110,
    OP_SLT = 6'b000111,
    OP_CNT = 6'b001000,
    OP_SLTU = 6'b001011,
    OP_AND = 6'b001101,
    OP_OR  = 6'b010001,
    OP_XOR = 6'b010101,
    OP_MOV = 6'b011001,
    OP_SHL = 6'b011101,
    OP_SHR = 6'b100001
  } aluOp_e;

  typedef struct packed {
    logic selNot;
    logic selPar;
    logic selCnt;
    logic selAnd;
    logic selOr;
    logic selXor;
    logic selMov;
    logic selShl;
    logic selShr;
    logic selAdd;
    logic selSub;
    logic selEq;
    logic selLt;
    logic selLtu;
  } aluStrobes_t;

endpackage

// File: rtl/stk_alu_decode.sv
module stk_alu_decode
  import stk_alu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStrobes_t     strobes
);

  always_comb begin
    strobes = '0;
    case (opCode)
      OP_NOT:  strobes.selNot = 1'b1;
      OP_PAR:  strobes.selPar = 1'b1;
      OP_CNT:  strobes.selCnt = 1'b1;
      OP_AND:  strobes.selAnd = 1'b1;
      OP_OR:   strobes.selOr  = 1'b1;
      OP_XOR:  strobes.selXor = 1'b1;
      OP_MOV:  strobes.selMov = 1'b1;
      OP_SHL:  strobes.selShl = 1'b1;
      OP_SHR:  strobes.selShr = 1'b1;
      OP_ADD:  strobes.selAdd = 1'b1;
      OP_SUB:  strobes.selSub = 1'b1;
      OP_SEQ:  strobes.selEq  = 1'b1;
      OP_SLT:  strobes.selLt  = 1'b1;
      OP_SLTU: strobes.selLtu = 1'b1;
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/stk_alu_datapath.sv
module stk_alu_datapath
  import stk_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  aluStrobes_t       strobes,
  output logic [DATA_W-1:0] result
);

  localparam int SH_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_W = $clog2(DATA_W + 1);

  // barrel shifter stages, one per bit of the shift amount
  logic [DATA_W-1:0] leftStage  [SH_W+1];
  logic [DATA_W-1:0] rightStage [SH_W+1];
  logic              shiftOver;
  logic [DATA_W-1:0] shlVal;
  logic [DATA_W-1:0] shrVal;

  assign leftStage[0]  = operandA;
  assign rightStage[0] = operandA;

  for (genvar k = 0; k < SH_W; k++) begin : g_shiftStage
    assign leftStage[k+1]  = operandB[k] ? (leftStage[k]  << (1 << k)) : leftStage[k];
    assign rightStage[k+1] = operandB[k] ? (rightStage[k] >> (1 << k)) : rightStage[k];
  end

  assign shiftOver = (32'(operandB) >= 32'(DATA_W));
  assign shlVal    = shiftOver ? '0 : leftStage[SH_W];
  assign shrVal    = shiftOver ? '0 : rightStage[SH_W];

  // set-bit count
  logic [CNT_W-1:0] countVal;
  always_comb begin
    countVal = '0;
    for (int i = 0; i < DATA_W; i++) begin
      countVal = countVal + CNT_W'(operandA[i]);
    end
  end

  logic parityBit;
  logic eqBit;
  logic ltSignedBit;
  logic ltUnsignedBit;
  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] diffVal;

  assign parityBit     = ^operandA;
  assign eqBit         = (operandA == operandB);
  assign ltSignedBit   = ($signed(operandA) < $signed(operandB));
  assign ltUnsignedBit = (operandA < operandB);
  assign sumVal        = operandA + operandB;
  assign diffVal       = operandA - operandB;

  // one-hot merge of the selected function
  always_comb begin
    result = '0;
    if (strobes.selNot) result |= ~operandA;
    if (strobes.selPar) result |= DATA_W'(parityBit);
    if (strobes.selCnt) result |= DATA_W'(countVal);
    if (strobes.selAnd) result |= operandA & operandB;
    if (strobes.selOr)  result |= operandA | operandB;
    if (strobes.selXor) result |= operandA ^ operandB;
    if (strobes.selMov) result |= operandB;
    if (strobes.selShl) result |= shlVal;
    if (strobes.selShr) result |= shrVal;
    if (strobes.selAdd) result |= sumVal;
    if (strobes.selSub) result |= diffVal;
    if (strobes.selEq)  result |= DATA_W'(eqBit);
    if (strobes.selLt)  result |= DATA_W'(ltSignedBit);
    if (strobes.selLtu) result |= DATA_W'(ltUnsignedBit);
  end

  always_comb begin
    // R12
    strobe_onehot_chk: assert ($onehot0(strobes))
      else $error("more than one function strobe active");
    // R12
    if (strobes == '0) begin
      unknown_zero_chk: assert (result == '0)
        else $error("unselected code produced nonzero result");
    end
    // R7
    if (strobes.selAdd) begin
      add_inverse_chk: assert (DATA_W'(result - operandB) == operandA)
        else $error("sum does not invert back to operandA");
    end
    // R8
    if (strobes.selSub) begin
      sub_inverse_chk: assert (DATA_W'(result + operandB) == operandA)
        else $error("difference does not invert back to operandA");
    end
    // R9
    if (strobes.selEq || strobes.selLt || strobes.selLtu || strobes.selPar) begin
      flag_width_chk: assert (result[DATA_W-1:1] == '0)
        else $error("flag result has upper bits set");
    end
    // R6
    if ((strobes.selShl || strobes.selShr) && shiftOver) begin
      shift_limit_chk: assert (result == '0)
        else $error("overlong shift left bits behind");
    end
    // R2
    parity_count_chk: assert (parityBit == countVal[0])
      else $error("parity and bit count disagree");
  end

endmodule

// File: rtl/stk_alu8.sv
module stk_alu8
  import stk_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  output logic [DATA_W-1:0] result
);

  aluStrobes_t strobes;

  stk_alu_decode i_decode (
    .opCode  (opCode),
    .strobes (strobes)
  );

  stk_alu_datapath #(.DATA_W(DATA_W)) i_datapath (
    .operandA (operandA),
    .operandB (operandB),
    .strobes  (strobes),
    .result   (result)
  );

endmodule

// File: tb/test_stk_alu8.sv
`timescale 1ns/1ps
module test_stk_alu8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0] opCode = 6'd0;
  logic [7:0] operandA = 8'd0;
  logic [7:0] operandB = 8'd0;
  logic [7:0] result;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  stk_alu8 i_stk_alu8 (
    .opCode   (opCode),
    .operandA (operandA),
    .operandB (operandB),
    .result   (result)
  );

  localparam int B_CNT = 26;
  localparam int B_LIST [B_CNT] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 15, 16, 17, 20,
                                    31, 32, 63, 64, 85, 127, 128, 129, 170, 200, 254, 255};

  function automatic string tagOf(int op);
    case (op)
      0:  return "R1";
      4:  return "R2";
      8:  return "R3";
      13, 17, 21: return "R4";
      25: return "R5";
      29, 33: return "R6";
      2:  return "R7";
      6:  return "R8";
      3:  return "R9";
      7:  return "R10";
      11: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic int ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  function automatic int toSigned(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int model(int op, int a, int b);
    case (op)
      0:  return 255 - a;
      4:  return ones(a) % 2;
      8:  return ones(a);
      13: return a & b;
      17: return a | b;
      21: return a ^ b;
      25: return b;
      29: return (b >= 8) ? 0 : (a * (1 << b)) % 256;
      33: return (b >= 8) ? 0 : a / (1 << b);
      2:  return (a + b) % 256;
      6:  return (a - b + 256) % 256;
      3:  return (a == b) ? 1 : 0;
      7:  return (toSigned(a) < toSigned(b)) ? 1 : 0;
      11: return (a < b) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic judge(string tag, int expected);
    compared++;
    if (int'(result) != expected) begin
      mismatched++;
      $display("FAIL %s op=%b a=%0d b=%0d actual=%0d expected=%0d",
               tag, opCode, operandA, operandB, result, expected);
    end
  endtask

  task automatic apply(int op, int a, int b);
    opCode   = 6'(op);
    operandA = 8'(a);
    operandB = 8'(b);
    #1;
    judge(tagOf(op), model(op, a, b));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired before sweep completed");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // initial state: inverse of zero operandA (R1)
    #1;
    judge("R1", 255);

    // named corner cases
    apply(4, 3, 20);      // R2 even ones -> 0
    apply(4, 7, 0);       // R2 odd ones -> 1
    apply(8, 3, 20);      // R3 count 2
    apply(8, 255, 0);     // R3 count 8
    apply(29, 1, 7);      // R6 left to msb -> 128
    apply(29, 255, 8);    // R6 left by 8 -> 0
    apply(33, 128, 7);    // R6 right to lsb -> 1
    apply(33, 255, 200);  // R6 right overlong -> 0
    apply(2, 200, 100);   // R7 wrap -> 44
    apply(6, 3, 20);      // R8 wrap -> 239
    apply(3, 85, 85);     // R9 equal -> 1
    apply(7, 255, 1);     // R10 -1 < 1 -> 1
    apply(7, 127, 128);   // R10 127 < -128 false -> 0
    apply(11, 127, 128);  // R11 -> 1
    apply(11, 255, 1);    // R11 -> 0
    apply(25, 9, 170);    // R5 -> 170
    apply(13, 3, 20);     // R4 and -> 0
    apply(63, 255, 255);  // R12 unknown -> 0

    // R13: change only operandB mid-clock with the move code, no edge between
    @(posedge clk);
    #1;
    opCode = 6'b011001;
    operandB = 8'd77;
    #0.5;
    judge("R13", 77);
    operandB = 8'd5;
    #0.5;
    judge("R13", 5);

    // exhaustive sweep over all codes and all operandA values
    for (int op = 0; op < 64; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int j = 0; j < B_CNT; j++) begin
          apply(op, a, B_LIST[j]);
        end
      end
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule